// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Path

This block sits behind the analog front end of a 100 Mb/s twisted-pair receiver. It runs on the recovered 125 MHz symbol clock and takes one digitised three-level sample per clock. It turns that stream into nibble-wide receive data for the media-independent interface. The path first converts level transitions back into code bits. A self-synchronising descrambler then removes the stream cipher. The block then finds the 5-bit symbol boundary from the start-of-stream delimiter, decodes each 5-bit code into a nibble, and launches the result on a divide-by-five receive clock.

A lock input from the clock-recovery loop gates everything. While it is low, nothing is delivered and carrier sense stays low. When it rises again, the descrambler must resynchronise on idle before any frame can be accepted. The data-valid flag frames each packet between its start and end delimiters. The error flag marks codes that are not valid data. Carrier sense follows the line with a fixed latency on both edges, and the block holds that latency within the window the link standard allows.

Top module: `fe_rx_symbol_path`

## Requirements
- R1: Each input sample is decoded as a code bit of 1 when its level (2'b00 zero, 2'b01 positive, 2'b11 negative) differs from the previous sample, and 0 otherwise.
- R2: The descrambler uses the key recurrence k[n] = k[n-11] xor k[n-9]. It declares sync only after SYNC_RUN consecutive received bits agree with an all-ones idle stream, and no symbol search takes place before sync.
- R3: The symbol boundary is taken from the 10-bit delimiter 11000 then 10001, received first bit first. rx_dv rises with the first nibble after that delimiter, and neither delimiter code is delivered.
- R4: Data codes decode to nibbles 0 to F in the order 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101, each code taken first bit first.
- R5: A code that is neither data, 01101 nor 11111 is delivered, while the frame is open, as one nibble period with rx_dv and rx_er both high. rx_er is never high without rx_dv.
- R6: A code of 01101 or 11111 closes the frame. That code is not delivered, rx_dv falls, and a new delimiter search starts.
- R7: crs rises between 11 and 15 symbol clocks after the first bit of the 11000 code is sampled at the input. rx_dv is never high while crs is low.
- R8: crs falls between 19 and 23 symbol clocks after the first bit of the closing 01101 code is sampled.
- R9: rx_clk is the symbol clock divided by five, high for two cycles and low for three. While lock is high, rxd, rx_dv and rx_er change only on the cycle where rx_clk falls.
- R10: While lock is low, rx_dv, rx_er, rxd and crs are held at 0 from the next cycle on and sync is lost. A frame sent during that time, or after lock returns but before a fresh sync run of idle, is not delivered.
- R11: After reset, rx_dv, rx_er, crs and rxd are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sym | input | 1 | Recovered symbol clock, nominally 125 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | Clock-recovery lock; low blocks all delivery |
| mlt3_lvl | input | 2 | Sampled line level: 00 zero, 01 positive, 11 negative |
| rx_clk | output | 1 | Receive clock, symbol clock divided by five |
| rxd | output | 4 | Receive nibble, launched on the falling edge of rx_clk |
| rx_dv | output | 1 | Receive data valid, framed by the delimiters |
| rx_er | output | 1 | Receive error for a non-data code inside a frame |
| crs | output | 1 | Carrier sense with fixed latency on both edges |

## Verification
The bench builds the block with SYNC_RUN=16 and CRS_HOLD=14. A short sync run keeps each idle gap to a few dozen bits, so one run can hold frames that carry all sixteen data codes in both orders, every one of the fourteen non-data codes that do not close a frame, and an end by idle instead of the end delimiter. CRS_HOLD=14 places the falling carrier edge in the middle of its window, and both carrier latencies are measured against the cycle on which the first delimiter bit was driven. The same setting also gives runs with lock low, a resync that is too short after lock returns, and a lock drop in the middle of a frame.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

  localparam int SYM_W    = 5;
  localparam int NIB_W    = 4;
  localparam int LFSR_W   = 11;
  localparam int TAP_B    = 9;
  localparam int RCLK_DIV = 5;
  localparam int RCLK_HI  = 2;

  typedef enum logic [1:0] {
    SYM_DATA = 2'd0,
    SYM_END  = 2'd1,
    SYM_BAD  = 2'd2
  } sym_kind_e;

  typedef struct packed {
    sym_kind_e          kind;
    logic [NIB_W-1:0]   nib;
  } sym_dec_t;

  localparam logic [SYM_W-1:0] CODE_J = 5'b11000;
  localparam logic [SYM_W-1:0] CODE_K = 5'b10001;
  localparam logic [SYM_W-1:0] CODE_T = 5'b01101;
  localparam logic [SYM_W-1:0] CODE_I = 5'b11111;
  localparam logic [2*SYM_W-1:0] SSD_PAT = {CODE_J, CODE_K};

  // A transition between consecutive samples carries a one.
  function automatic logic mlt3_bit(logic [1:0] prev_lvl, logic [1:0] cur_lvl);
    return prev_lvl != cur_lvl;
  endfunction

  // Key history h[k] holds the key bit from k+1 steps ago.
  function automatic logic key_next(logic [LFSR_W-1:0] h);
    return h[LFSR_W-1] ^ h[TAP_B-1];
  endfunction

  function automatic sym_dec_t sym_decode(logic [SYM_W-1:0] c);
    sym_dec_t d;
    d.kind = SYM_DATA;
    d.nib  = '0;
    case (c)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      CODE_T, CODE_I: d.kind = SYM_END;
      default: d.kind = SYM_BAD;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/fe_rx_mlt3.sv
module fe_rx_mlt3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock,
  input  logic [1:0] lvl,
  output logic       bit_o,
  output logic       bit_vld
);
  import fe_rx_pkg::*;

  logic [1:0] prev_lvl;
  logic       have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl  <= 2'b00;
      have_prev <= 1'b0;
      bit_o     <= 1'b0;
      bit_vld   <= 1'b0;
    end else if (!lock) begin
      prev_lvl  <= lvl;
      have_prev <= 1'b0;
      bit_o     <= 1'b0;
      bit_vld   <= 1'b0;
    end else begin
      prev_lvl  <= lvl;
      have_prev <= 1'b1;
      bit_o     <= mlt3_bit(prev_lvl, lvl);
      bit_vld   <= have_prev;
    end
  end

endmodule

// File: rtl/fe_rx_descram.sv
module fe_rx_descram #(
  parameter int SYNC_RUN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic in_bit,
  input  logic in_vld,
  output logic out_bit,
  output logic out_vld,
  output logic synced
);
  import fe_rx_pkg::*;

  localparam int RUN_W = $clog2(SYNC_RUN + 1);

  logic [LFSR_W-1:0] hist;
  logic [RUN_W-1:0]  run;
  logic              pred;
  logic              idle_key;
  logic              agree;

  assign pred     = key_next(hist);
  assign idle_key = ~in_bit;          // idle plain bits are all ones
  assign agree    = (pred == idle_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      run     <= '0;
      synced  <= 1'b0;
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else if (!lock) begin
      hist    <= '0;
      run     <= '0;
      synced  <= 1'b0;
      out_bit <= 1'b0;
      out_vld <= 1'b0;
    end else if (in_vld) begin
      if (synced) begin
        hist    <= {hist[LFSR_W-2:0], pred};
        out_bit <= in_bit ^ pred;
        out_vld <= 1'b1;
      end else begin
        hist    <= {hist[LFSR_W-2:0], idle_key};
        out_vld <= 1'b0;
        if (!agree) begin
          run <= '0;
        end else if (run == RUN_W'(SYNC_RUN - 1)) begin
          synced <= 1'b1;
        end else begin
          run <= run + 1'b1;
        end
      end
    end else begin
      out_vld <= 1'b0;
    end
  end

  AST_SYNC_ONLY_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !synced && !(in_vld && agree)) |=> !synced); // R2

endmodule

// File: rtl/fe_rx_framer.sv
module fe_rx_framer #(
  parameter int CRS_HOLD = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock,
  input  logic                bit_i,
  input  logic                vld_i,
  output logic                crs,
  output logic                sym_stb,
  output fe_rx_pkg::sym_dec_t sym,
  output logic                aligned
);
  import fe_rx_pkg::*;

  localparam int HOLD_W = $clog2(CRS_HOLD + 1);
  localparam int PH_W   = $clog2(SYM_W);

  logic [2*SYM_W-2:0] sh;
  logic [2*SYM_W-1:0] sh_n;
  logic [PH_W-1:0]    ph;
  logic [HOLD_W-1:0]  hold;
  logic               crs_raw;
  logic               ssd_hit;
  logic               sym_done;
  sym_dec_t           dec_n;

  assign sh_n     = {sh, bit_i};
  assign ssd_hit  = vld_i && !aligned && (sh_n == SSD_PAT);
  assign sym_done = vld_i && aligned && (ph == PH_W'(SYM_W - 1));
  assign dec_n    = sym_decode(sh_n[SYM_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      ph      <= '0;
      hold    <= '0;
      crs_raw <= 1'b0;
      crs     <= 1'b0;
      aligned <= 1'b0;
      sym_stb <= 1'b0;
      sym     <= '0;
    end else if (!lock) begin
      sh      <= '0;
      ph      <= '0;
      hold    <= '0;
      crs_raw <= 1'b0;
      crs     <= 1'b0;
      aligned <= 1'b0;
      sym_stb <= 1'b0;
      sym     <= '0;
    end else begin
      sym_stb <= 1'b0;
      crs     <= crs_raw;
      if (vld_i) sh <= sh_n[2*SYM_W-2:0];
      if (hold != '0) begin
        hold <= hold - 1'b1;
        if (hold == HOLD_W'(1)) crs_raw <= 1'b0;
      end
      if (ssd_hit) begin
        aligned <= 1'b1;
        ph      <= '0;
        crs_raw <= 1'b1;
        hold    <= '0;
      end else if (sym_done) begin
        ph      <= '0;
        sym_stb <= 1'b1;
        sym     <= dec_n;
        if (dec_n.kind == SYM_END) begin
          aligned <= 1'b0;
          hold    <= HOLD_W'(CRS_HOLD);
        end
      end else if (aligned && vld_i) begin
        ph <= ph + 1'b1;
      end
    end
  end

  AST_STROBE_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb |-> $past(aligned)); // R3

  AST_CRS_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && aligned && crs_raw) |=> crs); // R7

endmodule

// File: rtl/fe_rx_mii_out.sv
module fe_rx_mii_out (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         lock,
  input  logic                         sym_stb,
  input  fe_rx_pkg::sym_dec_t          sym,
  output logic                         rx_clk,
  output logic [fe_rx_pkg::NIB_W-1:0]  rxd,
  output logic                         rx_dv,
  output logic                         rx_er,
  output logic                         fall_evt
);
  import fe_rx_pkg::*;

  localparam int DIV_W = $clog2(RCLK_DIV);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] div_n;
  logic [NIB_W-1:0] h_nib;
  logic             h_dv;
  logic             h_er;

  assign div_n    = (div == DIV_W'(RCLK_DIV - 1)) ? '0 : div + 1'b1;
  assign fall_evt = (div == DIV_W'(RCLK_HI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div    <= '0;
      rx_clk <= 1'b0;
    end else begin
      div    <= div_n;
      rx_clk <= (div_n < DIV_W'(RCLK_HI));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_nib <= '0;
      h_dv  <= 1'b0;
      h_er  <= 1'b0;
      rxd   <= '0;
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
    end else if (!lock) begin
      h_nib <= '0;
      h_dv  <= 1'b0;
      h_er  <= 1'b0;
      rxd   <= '0;
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
    end else begin
      if (sym_stb) begin
        unique case (sym.kind)
          SYM_DATA: begin h_nib <= sym.nib; h_dv <= 1'b1; h_er <= 1'b0; end
          SYM_BAD:  begin h_nib <= '0;      h_dv <= 1'b1; h_er <= 1'b1; end
          default:  begin h_nib <= '0;      h_dv <= 1'b0; h_er <= 1'b0; end
        endcase
      end
      if (fall_evt) begin
        rxd   <= h_nib;
        rx_dv <= h_dv;
        rx_er <= h_er;
      end
    end
  end

  AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !fall_evt) |=> ($stable(rxd) && $stable(rx_dv) && $stable(rx_er))); // R9

  AST_CLK_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_clk) |=> !rx_clk); // R9

  AST_ER_INSIDE_DV: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> rx_dv); // R5

endmodule

// File: rtl/fe_rx_symbol_path.sv
module fe_rx_symbol_path #(
  parameter int SYNC_RUN = 24,
  parameter int CRS_HOLD = 14
) (
  input  logic       clk_sym,
  input  logic       rst_n,
  input  logic       lock,
  input  logic [1:0] mlt3_lvl,
  output logic       rx_clk,
  output logic [3:0] rxd,
  output logic       rx_dv,
  output logic       rx_er,
  output logic       crs
);
  import fe_rx_pkg::*;

  logic     code_bit, code_vld;
  logic     plain_bit, plain_vld;
  logic     synced;
  logic     aligned;
  logic     sym_stb;
  sym_dec_t sym;
  logic     fall_evt;

  fe_rx_mlt3 u_mlt3 (
    .clk(clk_sym), .rst_n(rst_n), .lock(lock), .lvl(mlt3_lvl),
    .bit_o(code_bit), .bit_vld(code_vld)
  );

  fe_rx_descram #(.SYNC_RUN(SYNC_RUN)) u_dsc (
    .clk(clk_sym), .rst_n(rst_n), .lock(lock),
    .in_bit(code_bit), .in_vld(code_vld),
    .out_bit(plain_bit), .out_vld(plain_vld), .synced(synced)
  );

  fe_rx_framer #(.CRS_HOLD(CRS_HOLD)) u_frm (
    .clk(clk_sym), .rst_n(rst_n), .lock(lock),
    .bit_i(plain_bit), .vld_i(plain_vld),
    .crs(crs), .sym_stb(sym_stb), .sym(sym), .aligned(aligned)
  );

  fe_rx_mii_out u_out (
    .clk(clk_sym), .rst_n(rst_n), .lock(lock),
    .sym_stb(sym_stb), .sym(sym),
    .rx_clk(rx_clk), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .fall_evt(fall_evt)
  );

  AST_ALIGN_NEEDS_SYNC: assert property (@(posedge clk_sym) disable iff (!rst_n)
    aligned |-> synced); // R2

  AST_LOCK_BLOCKS_OUT: assert property (@(posedge clk_sym) disable iff (!rst_n)
    !lock |=> (!rx_dv && !rx_er && !crs && rxd == 4'h0)); // R10

  AST_DV_UNDER_CRS: assert property (@(posedge clk_sym) disable iff (!rst_n)
    rx_dv |-> crs); // R7

  AST_FALL_MATCHES_CLK: assert property (@(posedge clk_sym) disable iff (!rst_n)
    fall_evt |=> !rx_clk); // R9

endmodule

// File: tb/sim_fe_rx_symbol_path.sv
`timescale 1ns/1ps
module sim_fe_rx_symbol_path;

  localparam int SYNC_RUN = 16;
  localparam int CRS_HOLD = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock = 1'b0;
  logic [1:0] lvl = 2'b00;
  wire        rx_clk;
  wire [3:0]  rxd;
  wire        rx_dv, rx_er, crs;

  fe_rx_symbol_path #(.SYNC_RUN(SYNC_RUN), .CRS_HOLD(CRS_HOLD)) u0 (
    .clk_sym(clk), .rst_n(rst_n), .lock(lock), .mlt3_lvl(lvl),
    .rx_clk(rx_clk), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // line coder: scrambler key history plus three-level encoder
  logic kh [16];
  int   kn = 11;
  int   lvl_ph = 0;
  int   last_edge = 0;

  initial begin
    for (int i = 0; i < 11; i++) kh[i] = ((11'h5A3 >> i) & 1) != 0;
  end

  function automatic logic [4:0] enc(input int n);
    logic [79:0] tbl;
    tbl = {5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
           5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};
    return tbl[n*5 +: 5];
  endfunction

  task automatic send_bit(input logic b);
    logic k;
    @(negedge clk);
    k = kh[(kn - 11) & 15] ^ kh[(kn - 9) & 15];
    kh[kn & 15] = k;
    kn++;
    if ((b ^ k) == 1'b1) lvl_ph = (lvl_ph + 1) % 4;
    lvl = (lvl_ph == 1) ? 2'b01 : (lvl_ph == 3) ? 2'b11 : 2'b00;
    last_edge = cyc + 1;
  endtask

  task automatic send_code(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  // monitor
  logic [3:0] got_nib [$];
  logic       got_er  [$];
  bit   prev_rclk = 1'b0, prev_crs = 1'b0, crs_seen = 1'b0;
  int   last_fall = -1, crs_rise = -1, crs_fall = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rclk && !rx_clk) begin
        if (last_fall >= 0) chk("R9 rx_clk period", (cyc - last_fall) == 5, cyc - last_fall, 5);
        last_fall = cyc;
        if (rx_dv) begin
          got_nib.push_back(rxd);
          got_er.push_back(rx_er);
        end
      end
      if (crs && !prev_crs) crs_rise = cyc;
      if (!crs && prev_crs) crs_fall = cyc;
      if (crs) crs_seen = 1'b1;
    end
    prev_rclk = rx_clk;
    prev_crs  = crs;
  end

  logic [4:0] body [$];
  logic [3:0] exp_nib [$];
  logic       exp_er  [$];
  int t_j, t_t;

  task automatic run_frame(input bit end_t);
    got_nib.delete(); got_er.delete();
    crs_rise = -1; crs_fall = -1; crs_seen = 1'b0;
    send_code(5'b11000); t_j = last_edge - 4;
    send_code(5'b10001);
    foreach (body[i]) send_code(body[i]);
    if (end_t) begin
      send_code(5'b01101); t_t = last_edge - 4;
      send_code(5'b00111);
    end
    send_idle(50);
  endtask

  task automatic compare(input string req);
    chk({req, " nibble count"}, got_nib.size() == exp_nib.size(), got_nib.size(), exp_nib.size());
    if (got_nib.size() == exp_nib.size()) begin
      foreach (exp_nib[i]) begin
        chk({req, " rx_er"}, got_er[i] == exp_er[i], got_er[i], exp_er[i]);
        if (!exp_er[i]) chk({req, " rxd"}, got_nib[i] == exp_nib[i], got_nib[i], exp_nib[i]);
      end
    end
  endtask

  task automatic clear_exp;
    body.delete(); exp_nib.delete(); exp_er.delete();
  endtask

  task automatic add_data(input int n);
    body.push_back(enc(n)); exp_nib.push_back(4'(n)); exp_er.push_back(1'b0);
  endtask

  initial begin
    logic [4:0] bad [14];
    bad = '{5'b11000, 5'b10001, 5'b00111, 5'b00100, 5'b00000, 5'b00001, 5'b00010,
            5'b00011, 5'b00101, 5'b00110, 5'b01000, 5'b01100, 5'b10000, 5'b11001};

    repeat (6) @(negedge clk);
    // R11 reset state
    chk("R11 rx_dv", rx_dv == 1'b0, rx_dv, 0);
    chk("R11 rx_er", rx_er == 1'b0, rx_er, 0);
    chk("R11 crs", crs == 1'b0, crs, 0);
    chk("R11 rxd", rxd == 4'h0, rxd, 0);
    rst_n = 1'b1;
    lock  = 1'b1;
    send_idle(60);
    chk("R2 idle gives no carrier", crs == 1'b0 && rx_dv == 1'b0, crs, 0);

    // frame A: every data code, both orders (R1 R2 R3 R4 R6 R7 R8)
    clear_exp();
    for (int n = 0; n < 16; n++) add_data(n);
    for (int n = 15; n >= 0; n--) add_data(n);
    run_frame(1'b1);
    compare("R4 data sweep");
    chk("R7 crs rise latency", crs_rise - t_j >= 11 && crs_rise - t_j <= 15, crs_rise - t_j, 12);
    chk("R8 crs fall latency", crs_fall - t_t >= 19 && crs_fall - t_t <= 23, crs_fall - t_t, 21);
    chk("R6 rx_dv low after end", rx_dv == 1'b0, rx_dv, 0);

    // frame B: each non-data, non-closing code between data (R5)
    clear_exp();
    for (int i = 0; i < 14; i++) begin
      add_data(i);
      body.push_back(bad[i]); exp_nib.push_back(4'h0); exp_er.push_back(1'b1);
    end
    add_data(15);
    run_frame(1'b1);
    compare("R5 error codes");
    chk("R8 crs fall latency B", crs_fall - t_t >= 19 && crs_fall - t_t <= 23, crs_fall - t_t, 21);

    // frame C: closed by idle instead of the end delimiter (R6)
    clear_exp();
    add_data(3); add_data(9); add_data(12);
    run_frame(1'b0);
    compare("R6 idle close");
    chk("R6 crs low after idle close", crs == 1'b0, crs, 0);

    // frame D: sent with lock low (R10)
    lock = 1'b0;
    clear_exp();
    add_data(1); add_data(2); add_data(4);
    exp_nib.delete(); exp_er.delete();
    send_idle(30);
    run_frame(1'b1);
    compare("R10 no lock");
    chk("R10 no carrier without lock", crs_seen == 1'b0, crs_seen, 0);

    // frame E: lock back but resync run too short (R2 R10)
    lock = 1'b1;
    send_idle(5);
    run_frame(1'b1);
    compare("R10 short resync");
    chk("R2 no carrier before sync", crs_seen == 1'b0, crs_seen, 0);

    // frame F: lock dropped inside an open frame (R3 R10)
    send_idle(60);
    clear_exp();
    for (int n = 0; n < 8; n++) add_data(n);
    send_code(5'b11000); send_code(5'b10001);
    foreach (body[i]) send_code(body[i]);
    @(negedge clk);
    chk("R3 rx_dv open in frame", rx_dv == 1'b1, rx_dv, 1);
    chk("R7 crs open in frame", crs == 1'b1, crs, 1);
    lock = 1'b0;
    @(negedge clk);
    chk("R10 rx_dv cleared", rx_dv == 1'b0, rx_dv, 0);
    chk("R10 crs cleared", crs == 1'b0, crs, 0);
    chk("R10 rxd cleared", rxd == 4'h0, rxd, 0);
    lock = 1'b1;

    // frame G: recovery after resync
    send_idle(60);
    clear_exp();
    add_data(10); add_data(5); add_data(0); add_data(15);
    run_frame(1'b1);
    compare("R10 recovery");
    chk("R7 crs rise latency G", crs_rise - t_j >= 11 && crs_rise - t_j <= 15, crs_rise - t_j, 12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule